// File: doc/BRIEF.md
# Triple-Redundant Gray Timestamp Capture

This block stamps the arrival time of hits on one detector channel in a way that survives a single upset in the time base. Three separate Gray-coded counters run side by side on the system clock. Together they form the chip's global time. A rising edge on the fast-discriminator hit line first passes through a two-stage synchronizer. It then freezes each counter's Gray value into a private per-channel register.

One cycle after that freeze, a bitwise two-of-three vote merges the three stored copies into the published timestamp. A one-cycle valid strobe marks the result. A disagreement flag goes out with the same strobe whenever the three stored copies are not identical, so a corrupted copy is both outvoted and reported.

The hit input may be asynchronous to the clock. A capture needs the line to go low and then high again. Holding the line high produces only one stamp.

Top module: `ts_tmr`

## Requirements
- R1: While rst_n is low, ts_out is 0, ts_valid is 0 and ts_mismatch is 0, and all three counters are cleared to zero.
- R2: Each counter advances by one on every clock edge after reset release and wraps modulo 2^W. The stamped value is the Gray code g = b ^ (b >> 1) of the count held just before the capturing edge.
- R3: If hit_in is first sampled high at clock edge N, the copies are latched at edge N+2 from the counts held before that edge. ts_valid is high after edge N+3.
- R4: ts_valid is high for exactly one clock cycle per capture.
- R5: Only a low-to-high transition of the synchronized hit starts a capture. Holding hit_in high for any number of cycles gives one capture, and a hit that arrives while a capture is being voted is ignored.
- R6: ts_out bit i is the majority of bit i of the three latched copies. With one counter copy corrupted, ts_out still equals the Gray time of the healthy copies.
- R7: ts_mismatch is high together with ts_valid when the three latched copies are not all equal, and low otherwise.
- R8: ts_out keeps its value in every cycle in which ts_valid is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; all counters and registers run on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| hit_in | input | 1 | Fast-discriminator hit, asynchronous to clk |
| ts_out | output | W | Voted Gray-coded timestamp |
| ts_valid | output | 1 | One-cycle strobe marking a new ts_out |
| ts_mismatch | output | 1 | High with ts_valid when the three latched copies differ |

## Verification
The hardest condition to reach from the ports is a disagreement among the three counter copies. In a healthy design the copies are always equal, so the vote and the mismatch flag never see a split. The bench forces one copy to an unrelated value across a whole capture window, once for each copy in turn. It then checks that the voted stamp still equals its own Gray time model and that the mismatch flag rises. A reset follows each of these runs, and a clean capture afterwards confirms that agreement is restored. Randomly spaced pulses of random width sweep the stamps across the counter wrap.

// File: rtl/ts_tmr.sv
module ts_tmr #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         hit_in,
  output logic [W-1:0] ts_out,
  output logic         ts_valid,
  output logic         ts_mismatch
);

  logic [W-1:0] bin_a, bin_b, bin_c;
  logic [W-1:0] gry_a, gry_b, gry_c;
  logic [W-1:0] lat_a, lat_b, lat_c;
  logic [W-1:0] voted;
  logic         hit_s1, hit_s2, hit_s3;
  logic         busy, take;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) bin_a <= '0;
    else        bin_a <= bin_a + 1'b1;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) bin_b <= '0;
    else        bin_b <= bin_b + 1'b1;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) bin_c <= '0;
    else        bin_c <= bin_c + 1'b1;

  assign gry_a = bin_a ^ (bin_a >> 1);
  assign gry_b = bin_b ^ (bin_b >> 1);
  assign gry_c = bin_c ^ (bin_c >> 1);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) {hit_s1, hit_s2, hit_s3} <= 3'b000;
    else        {hit_s1, hit_s2, hit_s3} <= {hit_in, hit_s1, hit_s2};

  assign take = hit_s2 & ~hit_s3 & ~busy;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      lat_a <= '0;
      lat_b <= '0;
      lat_c <= '0;
      busy  <= 1'b0;
    end else begin
      busy <= take;
      if (take) begin
        lat_a <= gry_a;
        lat_b <= gry_b;
        lat_c <= gry_c;
      end
    end

  assign voted = (lat_a & lat_b) | (lat_a & lat_c) | (lat_b & lat_c);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      ts_out      <= '0;
      ts_valid    <= 1'b0;
      ts_mismatch <= 1'b0;
    end else begin
      ts_valid    <= busy;
      ts_mismatch <= busy & ((lat_a != lat_b) | (lat_a != lat_c));
      if (busy) ts_out <= voted;
    end

  assert_valid_pulse_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ts_valid |=> !ts_valid);

  assert_valid_after_latch_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ts_valid |-> $past(busy));

  assert_mismatch_with_valid_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ts_mismatch |-> ts_valid);

  assert_out_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !ts_valid |-> $stable(ts_out));

  assert_one_capture_per_edge_R5: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> !busy);

endmodule

// File: tb/ts_tmr_test.sv
module ts_tmr_test;
  localparam int W = 8;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         hit_in = 1'b0;
  logic [W-1:0] ts_out;
  logic         ts_valid, ts_mismatch;
  logic [W-1:0] refcnt;
  int checks = 0;
  int errors = 0;
  int vcount = 0;

  ts_tmr #(.W(W)) uut (
    .clk(clk), .rst_n(rst_n), .hit_in(hit_in),
    .ts_out(ts_out), .ts_valid(ts_valid), .ts_mismatch(ts_mismatch)
  );

  always #5 clk = ~clk;

  always @(posedge clk or negedge rst_n)
    if (!rst_n) refcnt <= '0;
    else        refcnt <= refcnt + 1'b1;

  always @(posedge clk) if (ts_valid) vcount <= vcount + 1;

  function automatic logic [W-1:0] gray(input logic [W-1:0] b);
    return b ^ (b >> 1);
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    hit_in = 1'b0;
    repeat (3) @(negedge clk);
    chk("R1 ts_out", ts_out, 0);
    chk("R1 ts_valid", ts_valid, 0);
    chk("R1 ts_mismatch", ts_mismatch, 0);
    rst_n = 1'b1;
  endtask

  task automatic capture(input int hold, input logic exp_mm, input string tag);
    logic [W-1:0] exp;
    int v0;
    @(negedge clk);
    hit_in = 1'b1;
    @(posedge clk);
    @(posedge clk);
    @(posedge clk);
    #1 exp = gray(refcnt - 1'b1);
    chk({tag, " R3 no early valid"}, ts_valid, 0);
    @(posedge clk);
    #1;
    chk({tag, " R3 valid"}, ts_valid, 1);
    chk({tag, " R2/R6 ts_out"}, ts_out, exp);
    chk({tag, " R7 mismatch"}, ts_mismatch, exp_mm);
    @(posedge clk);
    #1;
    chk({tag, " R4 one-cycle valid"}, ts_valid, 0);
    chk({tag, " R8 hold"}, ts_out, exp);
    v0 = vcount;
    repeat (hold) @(posedge clk);
    #1 chk({tag, " R5 held high no recapture"}, vcount, v0);
    @(negedge clk);
    hit_in = 1'b0;
    repeat (3) @(negedge clk);
    chk({tag, " R8 hold idle"}, ts_out, exp);
  endtask

  initial begin
    #2000000;
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed));
    do_reset();
    capture(0, 1'b0, "directed first");
    capture(12, 1'b0, "directed long hold");
    for (int i = 0; i < 60; i++) begin
      repeat ($urandom_range(0, 9)) @(negedge clk);
      capture($urandom_range(0, 6), 1'b0, "random");
    end

    do_reset();
    repeat (5) @(negedge clk);
    force uut.bin_a = 8'hA5;
    capture(0, 1'b1, "fault copy a");
    release uut.bin_a;
    do_reset();
    repeat (7) @(negedge clk);
    force uut.bin_b = 8'h5A;
    capture(1, 1'b1, "fault copy b");
    release uut.bin_b;
    do_reset();
    repeat (9) @(negedge clk);
    force uut.bin_c = 8'hC3;
    capture(2, 1'b1, "fault copy c");
    release uut.bin_c;
    do_reset();
    capture(0, 1'b0, "recovered");

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule